// File: doc/BRIEF.md
# Boundary Test Cell Chain

This block places one test cell on every pin path between the core logic and the device pins. Some cells sit on input paths, carrying a pin value into the core. The others sit on output paths, carrying a core value out to a pin. Every cell has two stages: a capture/shift stage that forms one link of a serial chain, and a separate hold stage that feeds a two-way mux on the cell's path. An external test controller produces the strobes. It can load all cells in parallel, move the chain one position toward the serial output, or copy the chain word into the hold stages. A mode input chooses, for every cell, between passing the functional signal through and driving the held test value.

A tester typically shifts a full pattern in while the pins stay steady, copies it into the hold stages, and switches to test mode so that the output pins drive the pattern onto the board. It then captures what arrives at the input pins and shifts that word out for comparison. With the mode low the chain has no effect on the data paths, and it can still sample live traffic or preload a pattern ahead of a test.

Top module: `bscan_chain`

## Requirements
- R1: While the registered mode is functional, `core_in` equals `pin_in` and `pin_out` equals `core_out`, for every value and in the same cycle.
- R2: While the registered mode is test, `core_in[i]` drives the hold value of cell i. `pin_out[j]` drives the hold value of cell N_IN+j. Cells 0..N_IN-1 are the input cells and cells N_IN..N_CELLS-1 are the output cells.
- R3: A capture strobe loads every shift stage at one rising edge. With `cap_from_pin`=1, input cell i takes `pin_in[i]` and output cell N_IN+j takes the current `pin_out[j]`. With `cap_from_pin`=0, input cell i takes the current `core_in[i]` and output cell N_IN+j takes `core_out[j]`.
- R4: When shift is enabled at a rising edge, cell i takes the old value of cell i+1 and cell N_CELLS-1 takes `scan_in`. `scan_out` always shows the shift stage of cell 0.
- R5: When capture and shift are strobed together, the capture happens and the shift does not.
- R6: The hold stages take the whole shift word at a rising edge with `update_en`=1, and at no other time. Capture and shift therefore leave the driven pins unchanged.
- R7: `test_mode` is registered: the value sampled at a rising edge controls the muxes from that edge until the next one.
- R8: Synchronous active-low reset clears all shift and hold stages to 0 and selects functional mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode | input | 1 | 1 = drive held values, 0 = pass-through (registered) |
| cap_from_pin | input | 1 | Capture source: 1 = pin side, 0 = core side |
| capture_en | input | 1 | Parallel load strobe |
| shift_en | input | 1 | Serial shift strobe |
| update_en | input | 1 | Copy shift stages into hold stages |
| scan_in | input | 1 | Serial input, enters cell N_CELLS-1 |
| scan_out | output | 1 | Serial output, cell 0 shift stage |
| pin_in | input | N_IN | Values arriving at input pins |
| core_in | output | N_IN | Values delivered to the core |
| core_out | input | N_CELLS-N_IN | Values the core wants to drive |
| pin_out | output | N_CELLS-N_IN | Values driven onto output pins |

## Verification
The assertions assume that the strobes are synchronous to `clk`, that they are settled at every rising edge, and that reset is held for at least one edge. They allow any mix of strobes, including capture, shift and update in the same cycle, so the stimulus never has to keep them mutually exclusive. The bench changes all inputs half a period away from the active edge. It drives capture together with shift once, and update together with shift while patterns are being moved, so the priority and ordering rules are exercised at edges where a violation would show.

// File: rtl/bscan_pkg.sv
// Package: shared types for the boundary test cell chain.
// Assumes: nothing beyond a single test clock domain.
package bscan_pkg;

    // Direction of the pin path a cell sits on.
    typedef enum logic {
        CELL_IN  = 1'b0,   // pin -> core path
        CELL_OUT = 1'b1    // core -> pin path
    } cell_kind_e;

    // Strobe bundle distributed to every cell.
    typedef struct packed {
        logic capture;     // parallel load of shift stages
        logic shift;       // serial move toward cell 0
        logic update;      // copy shift stage into hold stage
        logic from_pin;    // capture source select
    } scan_ctl_t;

endpackage

// File: rtl/bscan_ctl.sv
// Module: bscan_ctl
// Registers the mode select and bundles the strobes for the cells.
// Assumes: strobes are synchronous to clk; reset is synchronous, active low.
module bscan_ctl (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  test_mode,
    input  logic                  cap_from_pin,
    input  logic                  capture_en,
    input  logic                  shift_en,
    input  logic                  update_en,
    output logic                  mode_q,
    output bscan_pkg::scan_ctl_t  ctl
);

    // Mode register: reset forces functional pass-through.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= test_mode;
    end

    // Strobe bundle: capture wins over shift inside each cell.
    always_comb begin
        ctl.capture  = capture_en;
        ctl.shift    = shift_en;
        ctl.update   = update_en;
        ctl.from_pin = cap_from_pin;
    end

endmodule

// File: rtl/bscan_cell.sv
// Module: bscan_cell
// One test cell: a capture/shift stage, a hold stage and a path mux.
// KIND picks which side of the path counts as the pin side.
// Assumes: func_in comes from the path source (pin for CELL_IN, core for CELL_OUT).
module bscan_cell #(
    parameter bscan_pkg::cell_kind_e KIND = bscan_pkg::CELL_IN
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  bscan_pkg::scan_ctl_t  ctl,
    input  logic                  mode,
    input  logic                  ser_in,
    input  logic                  func_in,
    output logic                  func_out,
    output logic                  shift_q,
    output logic                  hold_q
);

    logic pin_side;
    logic core_side;
    logic cap_val;

    // Path mux: pass-through or held test value.
    assign func_out = mode ? hold_q : func_in;

    // Side mapping, fixed per cell kind.
    generate
        if (KIND == bscan_pkg::CELL_IN) begin : g_in
            assign pin_side  = func_in;
            assign core_side = func_out;
        end else begin : g_out
            assign pin_side  = func_out;
            assign core_side = func_in;
        end
    endgenerate

    // Capture source select.
    assign cap_val = ctl.from_pin ? pin_side : core_side;

    // Shift stage: capture has priority over shift.
    always_ff @(posedge clk) begin
        if (!rst_n)           shift_q <= 1'b0;
        else if (ctl.capture) shift_q <= cap_val;
        else if (ctl.shift)   shift_q <= ser_in;
    end

    // Hold stage: changes only on update.
    always_ff @(posedge clk) begin
        if (!rst_n)          hold_q <= 1'b0;
        else if (ctl.update) hold_q <= shift_q;
    end

endmodule

// File: rtl/bscan_chain.sv
// Module: bscan_chain (top)
// Chain of N_CELLS test cells: cells 0..N_IN-1 on input paths,
// cells N_IN..N_CELLS-1 on output paths. scan_in enters the highest cell,
// scan_out leaves from cell 0.
// Assumes: 1 <= N_IN < N_CELLS; strobes come from an external controller.
module bscan_chain #(
    parameter int N_CELLS = 8,
    parameter int N_IN    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      test_mode,
    input  logic                      cap_from_pin,
    input  logic                      capture_en,
    input  logic                      shift_en,
    input  logic                      update_en,
    input  logic                      scan_in,
    output logic                      scan_out,
    input  logic [N_IN-1:0]           pin_in,
    output logic [N_IN-1:0]           core_in,
    input  logic [N_CELLS-N_IN-1:0]   core_out,
    output logic [N_CELLS-N_IN-1:0]   pin_out
);

    localparam int N_OUT = N_CELLS - N_IN;

    logic                  mode_q;
    bscan_pkg::scan_ctl_t  ctl;
    logic [N_CELLS-1:0]    shift_vec;
    logic [N_CELLS-1:0]    hold_vec;
    logic [N_CELLS-1:0]    ser_vec;
    logic [N_CELLS-1:0]    fin_vec;
    logic [N_CELLS-1:0]    fout_vec;

    // Mode register and strobe bundle.
    bscan_ctl u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .test_mode    (test_mode),
        .cap_from_pin (cap_from_pin),
        .capture_en   (capture_en),
        .shift_en     (shift_en),
        .update_en    (update_en),
        .mode_q       (mode_q),
        .ctl          (ctl)
    );

    // Path sources and destinations in cell order.
    assign fin_vec  = {core_out, pin_in};
    assign core_in  = fout_vec[N_IN-1:0];
    assign pin_out  = fout_vec[N_CELLS-1:N_IN];
    assign scan_out = shift_vec[0];

    // Cell array with serial links toward cell 0.
    generate
        for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
            localparam bscan_pkg::cell_kind_e K =
                (g < N_IN) ? bscan_pkg::CELL_IN : bscan_pkg::CELL_OUT;
            if (g == N_CELLS - 1) begin : g_head
                assign ser_vec[g] = scan_in;
            end else begin : g_link
                assign ser_vec[g] = shift_vec[g+1];
            end
            bscan_cell #(.KIND(K)) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .ctl      (ctl),
                .mode     (mode_q),
                .ser_in   (ser_vec[g]),
                .func_in  (fin_vec[g]),
                .func_out (fout_vec[g]),
                .shift_q  (shift_vec[g]),
                .hold_q   (hold_vec[g])
            );
        end
    endgenerate

    // Elaboration guard on the cell split.
    initial begin
        if (N_IN < 1 || N_OUT < 1)
            $error("bscan_chain needs at least one cell of each kind");
    end

endmodule

// File: rtl/bscan_chain_chk.sv
// Module: bscan_chain_chk
// Property checker bound to bscan_chain.
// Assumes: inputs settled at each rising edge of clk.
module bscan_chain_chk #(
    parameter int N_CELLS = 8,
    parameter int N_IN    = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     test_mode,
    input logic                     cap_from_pin,
    input logic                     capture_en,
    input logic                     shift_en,
    input logic                     update_en,
    input logic                     scan_in,
    input logic                     scan_out,
    input logic [N_IN-1:0]          pin_in,
    input logic [N_IN-1:0]          core_in,
    input logic [N_CELLS-N_IN-1:0]  core_out,
    input logic [N_CELLS-N_IN-1:0]  pin_out,
    input logic                     mode_q,
    input logic [N_CELLS-1:0]       shift_vec,
    input logic [N_CELLS-1:0]       hold_vec
);

    // R1: functional mode is transparent.
    assert_pass_through_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> (core_in == pin_in) && (pin_out == core_out));

    // R2: test mode drives held values.
    assert_drive_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> (pin_out == hold_vec[N_CELLS-1:N_IN]) && (core_in == hold_vec[N_IN-1:0]));

    // R3: pin-side capture of input cells.
    assert_capture_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && cap_from_pin) |=> shift_vec[N_IN-1:0] == $past(pin_in));

    // R4: serial move toward cell 0.
    assert_shift_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !capture_en) |=>
            (scan_out == $past(shift_vec[1])) && (shift_vec[N_CELLS-1] == $past(scan_in)));

    // R5: capture beats shift on the output cells too.
    assert_capture_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && shift_en && !cap_from_pin) |=>
            shift_vec[N_CELLS-1:N_IN] == $past(core_out));

    // R6: hold stages only move on update.
    assert_hold_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !update_en |=> $stable(hold_vec));

    assert_hold_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        update_en |=> hold_vec == $past(shift_vec));

    // R7: mode is the registered select.
    assert_mode_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> mode_q == $past(test_mode));

endmodule

bind bscan_chain bscan_chain_chk #(.N_CELLS(N_CELLS), .N_IN(N_IN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .test_mode    (test_mode),
    .cap_from_pin (cap_from_pin),
    .capture_en   (capture_en),
    .shift_en     (shift_en),
    .update_en    (update_en),
    .scan_in      (scan_in),
    .scan_out     (scan_out),
    .pin_in       (pin_in),
    .core_in      (core_in),
    .core_out     (core_out),
    .pin_out      (pin_out),
    .mode_q       (mode_q),
    .shift_vec    (shift_vec),
    .hold_vec     (hold_vec)
);

// File: tb/test_bscan_chain.sv
// Bench: sweeps all 6-bit patterns through a 3+3 cell chain against a
// bench-side model of the requirements.
module test_bscan_chain;

    localparam int NC = 6;
    localparam int NI = 3;
    localparam int NO = NC - NI;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic rst_n = 1'b0;
    logic test_mode = 1'b0, cap_from_pin = 1'b0;
    logic capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0;
    logic scan_in = 1'b0;
    logic scan_out;
    logic [NI-1:0] pin_in = '0;
    logic [NI-1:0] core_in;
    logic [NO-1:0] core_out = '0;
    logic [NO-1:0] pin_out;

    int checks = 0;
    int errors = 0;

    // Bench model of the chain state.
    logic [NC-1:0] m_sh, m_hd;
    logic          m_mode;

    bscan_chain #(.N_CELLS(NC), .N_IN(NI)) i_bscan_chain (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
        .cap_from_pin(cap_from_pin), .capture_en(capture_en),
        .shift_en(shift_en), .update_en(update_en), .scan_in(scan_in),
        .scan_out(scan_out), .pin_in(pin_in), .core_in(core_in),
        .core_out(core_out), .pin_out(pin_out)
    );

    function automatic logic [NO-1:0] exp_pin_out();
        return m_mode ? m_hd[NC-1:NI] : core_out;
    endfunction

    function automatic logic [NI-1:0] exp_core_in();
        return m_mode ? m_hd[NI-1:0] : pin_in;
    endfunction

    task automatic check(string tag, logic [NC:0] act, logic [NC:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s {scan_out,pin_out,core_in} actual %b expected %b", tag, act, exp);
        end
    endtask

    // One clock: advance the model from pre-edge inputs, compare after the edge.
    task automatic tick(string tag);
        logic [NC-1:0] nsh, nhd;
        logic nmode;
        if (!rst_n) begin
            nsh = '0; nhd = '0; nmode = 1'b0;
        end else begin
            nsh = m_sh;
            if (capture_en) begin
                nsh[NI-1:0]  = cap_from_pin ? pin_in : exp_core_in();
                nsh[NC-1:NI] = cap_from_pin ? exp_pin_out() : core_out;
            end else if (shift_en) begin
                nsh = {scan_in, m_sh[NC-1:1]};
            end
            nhd   = update_en ? m_sh : m_hd;
            nmode = test_mode;
        end
        @(posedge clk);
        #2;
        m_sh = nsh; m_hd = nhd; m_mode = nmode;
        check(tag, {scan_out, pin_out, core_in}, {m_sh[0], exp_pin_out(), exp_core_in()});
        #2;
    endtask

    task automatic shift_word(logic [NC-1:0] w, string tag);
        shift_en = 1'b1;
        for (int k = 0; k < NC; k++) begin
            scan_in = w[k];
            tick(tag);
        end
        shift_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R8: reset state.
        tick("R8"); tick("R8");
        rst_n = 1'b1;

        // R1: pass-through for every input pattern.
        for (int v = 0; v < 64; v++) begin
            pin_in = v[2:0]; core_out = v[5:3];
            tick("R1");
        end

        // R4/R6/R7/R2: load each pattern, update, drive, then shift with pins steady.
        for (int p = 0; p < 64; p++) begin
            shift_word(p[NC-1:0], "R4");
            update_en = 1'b1; tick("R6"); update_en = 1'b0;
            test_mode = 1'b1; pin_in = ~p[2:0]; core_out = ~p[5:3];
            tick("R7");
            tick("R2");
            shift_en = 1'b1;
            for (int k = 0; k < 3; k++) begin
                scan_in = k[0]; tick("R6");
            end
            shift_en = 1'b0;
            test_mode = 1'b0;
            tick("R7");
        end

        // R3: capture from both sides in both modes, then shift the word out.
        for (int md = 0; md < 2; md++) begin
            for (int src = 0; src < 2; src++) begin
                for (int v = 0; v < 64; v++) begin
                    test_mode = md[0]; cap_from_pin = src[0];
                    pin_in = v[2:0]; core_out = v[5:3];
                    capture_en = 1'b1; tick("R3"); capture_en = 1'b0;
                    shift_word(6'(v * 5 + 3), "R4");
                end
            end
        end

        // R5: capture and shift together, from both sources.
        for (int src = 0; src < 2; src++) begin
            cap_from_pin = src[0]; pin_in = 3'b101; core_out = 3'b011;
            capture_en = 1'b1; shift_en = 1'b1; scan_in = 1'b1;
            tick("R5");
            capture_en = 1'b0; shift_en = 1'b0;
            shift_word(6'b000000, "R5");
        end

        // R6: update during shift takes the pre-edge word.
        test_mode = 1'b1;
        shift_en = 1'b1; update_en = 1'b1; scan_in = 1'b0;
        tick("R6"); tick("R6");
        shift_en = 1'b0; update_en = 1'b0;

        // R8: reset in test mode with nonzero holds.
        shift_word(6'b111111, "R4");
        update_en = 1'b1; tick("R6"); update_en = 1'b0;
        tick("R2");
        rst_n = 1'b0; tick("R8");
        rst_n = 1'b1; test_mode = 1'b0; tick("R8");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule